// File: doc/BRIEF.md
# SPI Loopback Fault-Injection Controller

This block sits between the SPI pins and the SPI shift kernel. It lets a test program corrupt the receive path on purpose, so that the kernel's error detectors can be proven to work. It can do four things: invert the looped-back receive data, flip the received parity bit, and force the incoming slave-enable line high (to provoke a timeout) or low (to provoke a desync). It also watches the chip-select pins during a transfer and records any disagreement with the kernel's intended chip-select pattern in a sticky flag.

All of this is steered through a single 32-bit control word on a plain register bus. Writes to the word are accepted only with privilege. Nothing has any effect unless a 4-bit key field holds the unlock code. Once a slave-enable force has begun, it is held until the kernel reports idle, whatever happens to the control word meanwhile.

Top module: `spi_lpbk_fault_ctrl`

## Requirements
- R1: Every fault effect (R2 to R5) and the chip-select compare (R7) are active only while the key field, bits 11:8 of the control word, reads 0xA. With any other key value, rx_to_kernel equals rx_pin_in, par_to_kernel equals par_in, and no new force or compare failure starts.
- R2: With the key open and bit 20 set, rx_to_kernel is the inverse of rx_pin_in in the same cycle.
- R3: With the key open and bit 18 set, par_to_kernel is the inverse of par_in in the same cycle.
- R4: With the key open, bit 17 set and sena_pin_func high, a cycle with xfer_start high drives sena_to_kernel to 1 in that same cycle. From the next cycle it holds 1 until a cycle with kernel_idle high and no new start.
- R5: With the key open, bit 19 set and sena_pin_func high, xfer_start likewise starts forcing sena_to_kernel to 0, held until idle. When both forces are active, forcing to 1 takes precedence. With no force active, sena_to_kernel equals sena_pin_in.
- R6: An active hold survives clearing of its control bit or the key. Only kernel_idle (with no simultaneous start) or reset releases it.
- R7: While the key is open and xfer_active is high, a mismatch between cs_pin_in and cs_expect on any pin whose cs_pin_func bit is 1 sets the fail flag at bit 24 after the next clock edge. Pins whose cs_pin_func bit is 0 are ignored.
- R8: A privileged write with bit 24 set clears the fail flag. Writing 0 to bit 24 leaves it unchanged. A new mismatch in the same cycle wins over the clear.
- R9: A write with bus_priv low changes nothing. bus_rdata always shows the current control word.
- R10: After reset every field reads 0. Only bits 24, 20:17 and 11:8 are implemented; every other bit of bus_rdata always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe for the control word |
| bus_priv | input | 1 | Privilege qualifier for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current control word |
| rx_pin_in | input | 1 | Looped-back serial receive data |
| rx_to_kernel | output | 1 | Receive data passed to the kernel |
| par_in | input | 1 | Received parity bit |
| par_to_kernel | output | 1 | Parity bit passed to the kernel |
| sena_pin_in | input | 1 | Incoming slave-enable pin level |
| sena_pin_func | input | 1 | Slave-enable pin configured as functional |
| xfer_start | input | 1 | Kernel starts a transmission this cycle |
| kernel_idle | input | 1 | Kernel is in its idle state |
| sena_to_kernel | output | 1 | Slave-enable level seen by the kernel |
| xfer_active | input | 1 | A transfer is in progress |
| cs_pin_in | input | NUM_CS | Looped-back chip-select pin levels |
| cs_pin_func | input | NUM_CS | Per-pin functional mask |
| cs_expect | input | NUM_CS | Pin pattern implied by the internal chip-select number |

## Verification
The hardest situation to reach is a slave-enable hold that outlives its own cause. A force must be started, then its control bit and the key must be withdrawn, and then the kernel must stay out of idle across several cycles before it finally reports idle. A start that coincides with idle must also be covered. Directed sequences build each of these orderings on purpose, for both the high and the low force. A long randomized phase then mixes privileged and unprivileged writes, sparse chip-select mismatches and random idle and start pulses, while a behavioural model is compared every cycle.

// File: rtl/spi_lpbk_pkg.sv
package spi_lpbk_pkg;

    localparam int REG_W = 32;
    localparam int KEY_W = 4;
    localparam logic [KEY_W-1:0] KEY_OPEN = 4'hA;

    // bit positions in the control word
    localparam int POS_FLAG  = 24;
    localparam int POS_INV   = 20;
    localparam int POS_LOW   = 19;
    localparam int POS_PAR   = 18;
    localparam int POS_HIGH  = 17;
    localparam int POS_KEY   = 8;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             inv_rx;
        logic             force_low;
        logic             flip_par;
        logic             force_high;
    } lpbk_ctrl_t;

    typedef enum logic [0:0] {
        HOLD_HIGH = 1'b0,
        HOLD_LOW  = 1'b1
    } hold_kind_e;

    localparam int NUM_HOLD = 2;

    function automatic lpbk_ctrl_t decode_ctrl(input logic [REG_W-1:0] w);
        lpbk_ctrl_t c;
        c.key        = w[POS_KEY +: KEY_W];
        c.inv_rx     = w[POS_INV];
        c.force_low  = w[POS_LOW];
        c.flip_par   = w[POS_PAR];
        c.force_high = w[POS_HIGH];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] encode_reg(input lpbk_ctrl_t c, input logic flag);
        logic [REG_W-1:0] w;
        w = '0;
        w[POS_KEY +: KEY_W] = c.key;
        w[POS_INV]          = c.inv_rx;
        w[POS_LOW]          = c.force_low;
        w[POS_PAR]          = c.flip_par;
        w[POS_HIGH]         = c.force_high;
        w[POS_FLAG]         = flag;
        return w;
    endfunction

    function automatic logic is_armed(input lpbk_ctrl_t c);
        return c.key == KEY_OPEN;
    endfunction

endpackage

// File: rtl/spi_lpbk_regs.sv
module spi_lpbk_regs
    import spi_lpbk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             priv,
    input  logic [REG_W-1:0] wdata,
    input  logic             fail_set,
    output lpbk_ctrl_t       ctrl,
    output logic             fail_flag
);

    logic wr_ok;
    assign wr_ok = wr_en && priv;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            fail_flag <= 1'b0;
        end else begin
            if (wr_ok) begin
                ctrl <= decode_ctrl(wdata);
            end
            if (fail_set) begin
                fail_flag <= 1'b1;
            end else if (wr_ok && wdata[POS_FLAG]) begin
                fail_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_lpbk_hold.sv
module spi_lpbk_hold (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic release_i,
    output logic hold_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else if (set_i) begin
            hold_q <= 1'b1;
        end else if (release_i) begin
            hold_q <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_lpbk_sena_force.sv
module spi_lpbk_sena_force
    import spi_lpbk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lpbk_ctrl_t ctrl,
    input  logic       armed,
    input  logic       pin_level,
    input  logic       pin_func,
    input  logic       xfer_start,
    input  logic       kernel_idle,
    output logic       sena_out
);

    logic [NUM_HOLD-1:0] start_hit;
    logic [NUM_HOLD-1:0] held;
    logic [NUM_HOLD-1:0] active;

    for (genvar k = 0; k < NUM_HOLD; k++) begin : g_hold
        localparam hold_kind_e KIND = hold_kind_e'(k);
        logic want;
        if (KIND == HOLD_HIGH) begin : g_hi
            assign want = ctrl.force_high;
        end else begin : g_lo
            assign want = ctrl.force_low;
        end
        assign start_hit[k] = armed && want && pin_func && xfer_start;

        spi_lpbk_hold u_hold (
            .clk       (clk),
            .rst       (rst),
            .set_i     (start_hit[k]),
            .release_i (kernel_idle),
            .hold_q    (held[k])
        );

        assign active[k] = start_hit[k] || held[k];
    end

    always_comb begin
        if (active[HOLD_HIGH]) begin
            sena_out = 1'b1;
        end else if (active[HOLD_LOW]) begin
            sena_out = 1'b0;
        end else begin
            sena_out = pin_level;
        end
    end

endmodule

// File: rtl/spi_lpbk_cs_cmp.sv
module spi_lpbk_cs_cmp #(
    parameter int NUM_CS = 8
) (
    input  logic              armed,
    input  logic              xfer_active,
    input  logic [NUM_CS-1:0] pin_level,
    input  logic [NUM_CS-1:0] pin_func,
    input  logic [NUM_CS-1:0] expect_level,
    output logic              fail_set
);

    logic [NUM_CS-1:0] miss;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_pin
        assign miss[i] = pin_func[i] && (pin_level[i] != expect_level[i]);
    end

    assign fail_set = armed && xfer_active && (|miss);

endmodule

// File: rtl/spi_lpbk_fault_ctrl.sv
module spi_lpbk_fault_ctrl
    import spi_lpbk_pkg::*;
#(
    parameter int NUM_CS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic              bus_priv,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_pin_in,
    output logic              rx_to_kernel,
    input  logic              par_in,
    output logic              par_to_kernel,
    input  logic              sena_pin_in,
    input  logic              sena_pin_func,
    input  logic              xfer_start,
    input  logic              kernel_idle,
    output logic              sena_to_kernel,
    input  logic              xfer_active,
    input  logic [NUM_CS-1:0] cs_pin_in,
    input  logic [NUM_CS-1:0] cs_pin_func,
    input  logic [NUM_CS-1:0] cs_expect
);

    lpbk_ctrl_t ctrl;
    logic       fail_flag;
    logic       fail_set;
    logic       armed;

    spi_lpbk_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr_en),
        .priv      (bus_priv),
        .wdata     (bus_wdata),
        .fail_set  (fail_set),
        .ctrl      (ctrl),
        .fail_flag (fail_flag)
    );

    assign armed     = is_armed(ctrl);
    assign bus_rdata = encode_reg(ctrl, fail_flag);

    assign rx_to_kernel  = rx_pin_in ^ (armed && ctrl.inv_rx);
    assign par_to_kernel = par_in ^ (armed && ctrl.flip_par);

    spi_lpbk_sena_force u_sena (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .armed       (armed),
        .pin_level   (sena_pin_in),
        .pin_func    (sena_pin_func),
        .xfer_start  (xfer_start),
        .kernel_idle (kernel_idle),
        .sena_out    (sena_to_kernel)
    );

    spi_lpbk_cs_cmp #(.NUM_CS(NUM_CS)) u_cs (
        .armed        (armed),
        .xfer_active  (xfer_active),
        .pin_level    (cs_pin_in),
        .pin_func     (cs_pin_func),
        .expect_level (cs_expect),
        .fail_set     (fail_set)
    );

endmodule

// File: rtl/spi_lpbk_fault_ctrl_chk.sv
module spi_lpbk_fault_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr_en,
    input logic        bus_priv,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        rx_pin_in,
    input logic        rx_to_kernel,
    input logic        par_in,
    input logic        par_to_kernel,
    input logic        sena_pin_in,
    input logic        sena_pin_func,
    input logic        xfer_start,
    input logic        kernel_idle,
    input logic        sena_to_kernel
);

    logic key_open;
    assign key_open = (bus_rdata[11:8] == 4'hA);

    // R1: locked key leaves data and parity untouched
    assert_locked_pass_R1: assert property (@(posedge clk) disable iff (rst)
        !key_open |-> (rx_to_kernel == rx_pin_in) && (par_to_kernel == par_in));

    // R4: start with high force requested drives the line high at once
    assert_timeout_start_R4: assert property (@(posedge clk) disable iff (rst)
        (key_open && bus_rdata[17] && sena_pin_func && xfer_start) |-> sena_to_kernel);

    // R6: a high force outside idle persists to the next cycle
    assert_hold_persists_R6: assert property (@(posedge clk) disable iff (rst)
        (sena_to_kernel && !sena_pin_in && !kernel_idle) |=> sena_to_kernel);

    // R8: the flag stays set unless a privileged write-one clears it
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[24] && !(bus_wr_en && bus_priv && bus_wdata[24])) |=> bus_rdata[24]);

    // R9: unprivileged writes leave the control fields alone
    assert_nopriv_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr_en && bus_priv) |=> $stable(bus_rdata[20:8]));

    // R10: unimplemented bits read as zero
    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[31:25] == 7'd0) && (bus_rdata[23:21] == 3'd0)
        && (bus_rdata[16:12] == 5'd0) && (bus_rdata[7:0] == 8'd0));

endmodule

bind spi_lpbk_fault_ctrl spi_lpbk_fault_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_wr_en      (bus_wr_en),
    .bus_priv       (bus_priv),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .rx_pin_in      (rx_pin_in),
    .rx_to_kernel   (rx_to_kernel),
    .par_in         (par_in),
    .par_to_kernel  (par_to_kernel),
    .sena_pin_in    (sena_pin_in),
    .sena_pin_func  (sena_pin_func),
    .xfer_start     (xfer_start),
    .kernel_idle    (kernel_idle),
    .sena_to_kernel (sena_to_kernel)
);

// File: tb/spi_lpbk_fault_ctrl_tb.sv
module spi_lpbk_fault_ctrl_tb;

    localparam int NCS = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_wr_en = 1'b0, bus_priv = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           rx_pin_in = 1'b0, rx_to_kernel;
    logic           par_in = 1'b0, par_to_kernel;
    logic           sena_pin_in = 1'b0, sena_pin_func = 1'b0;
    logic           xfer_start = 1'b0, kernel_idle = 1'b1, sena_to_kernel;
    logic           xfer_active = 1'b0;
    logic [NCS-1:0] cs_pin_in = '0, cs_pin_func = '0, cs_expect = '0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_lpbk_fault_ctrl #(.NUM_CS(NCS)) u_dut (.*);

    // behavioural reference state
    bit [3:0] m_key;
    bit m_inv, m_low, m_par, m_high, m_flag, m_hold_hi, m_hold_lo;

    function automatic bit m_open();
        return m_key == 4'hA;
    endfunction
    function automatic bit m_start_hi();
        return m_open() && m_high && sena_pin_func && xfer_start;
    endfunction
    function automatic bit m_start_lo();
        return m_open() && m_low && sena_pin_func && xfer_start;
    endfunction
    function automatic bit m_cs_bad();
        bit bad = 1'b0;
        for (int i = 0; i < NCS; i++)
            if (cs_pin_func[i] && (cs_pin_in[i] != cs_expect[i])) bad = 1'b1;
        return m_open() && xfer_active && bad;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_key = 0; m_inv = 0; m_low = 0; m_par = 0; m_high = 0;
            m_flag = 0; m_hold_hi = 0; m_hold_lo = 0;
        end else begin
            bit s_hi, s_lo, bad, wok;
            s_hi = m_start_hi();
            s_lo = m_start_lo();
            bad  = m_cs_bad();
            wok  = bus_wr_en && bus_priv;
            if (s_hi) m_hold_hi = 1; else if (kernel_idle) m_hold_hi = 0;
            if (s_lo) m_hold_lo = 1; else if (kernel_idle) m_hold_lo = 0;
            if (bad) m_flag = 1; else if (wok && bus_wdata[24]) m_flag = 0;
            if (wok) begin
                m_key  = bus_wdata[11:8];
                m_inv  = bus_wdata[20];
                m_low  = bus_wdata[19];
                m_par  = bus_wdata[18];
                m_high = bus_wdata[17];
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison, mid-cycle
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit e_sena;
            logic [31:0] e_rd;
            e_rd = 32'd0;
            e_rd[24] = m_flag; e_rd[20] = m_inv; e_rd[19] = m_low;
            e_rd[18] = m_par; e_rd[17] = m_high; e_rd[11:8] = m_key;
            if (m_start_hi() || m_hold_hi) e_sena = 1'b1;
            else if (m_start_lo() || m_hold_lo) e_sena = 1'b0;
            else e_sena = sena_pin_in;
            check("R1 R2 rx", {31'd0, rx_to_kernel}, {31'd0, rx_pin_in ^ (m_open() && m_inv)});
            check("R1 R3 par", {31'd0, par_to_kernel}, {31'd0, par_in ^ (m_open() && m_par)});
            check("R4 R5 R6 sena", {31'd0, sena_to_kernel}, {31'd0, e_sena});
            check("R7 R8 R9 R10 rdata", bus_rdata, e_rd);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        bus_wr_en = 0; xfer_start = 0;
    endtask

    task automatic wr(input bit priv, input logic [31:0] d);
        bus_wr_en = 1; bus_priv = priv; bus_wdata = d;
        tick();
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R10 reset value", bus_rdata, 32'd0);
        tick();

        // R9: unprivileged write must not land
        wr(1'b0, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R9 unprivileged write", bus_rdata, 32'd0);

        // R1: controls set with a wrong key have no effect
        wr(1'b1, 32'h001E_0500);
        rx_pin_in = 1; par_in = 0;
        @(negedge clk);
        check("R1 locked rx", {31'd0, rx_to_kernel}, 32'd1);
        check("R10 unimplemented bits", bus_rdata, 32'h001E_0500);
        tick();

        // R2 R3 open key
        wr(1'b1, 32'h0014_0A00);
        rx_pin_in = 0; par_in = 1;
        @(negedge clk);
        check("R2 inverted rx", {31'd0, rx_to_kernel}, 32'd1);
        check("R3 flipped parity", {31'd0, par_to_kernel}, 32'd0);
        tick();

        // R4 R6: high force, then control withdrawn before idle
        wr(1'b1, 32'h0002_0A00);
        sena_pin_func = 1; sena_pin_in = 0; kernel_idle = 1; xfer_start = 1;
        @(negedge clk);
        check("R4 start with idle", {31'd0, sena_to_kernel}, 32'd1);
        tick();
        kernel_idle = 0;
        wr(1'b1, 32'h0000_0000);
        repeat (3) tick();
        @(negedge clk);
        check("R6 hold after key cleared", {31'd0, sena_to_kernel}, 32'd1);
        kernel_idle = 1;
        tick();
        @(negedge clk);
        check("R6 release at idle", {31'd0, sena_to_kernel}, 32'd0);

        // R5: low force, and precedence when both requested
        wr(1'b1, 32'h0008_0A00);
        sena_pin_in = 1; kernel_idle = 0; xfer_start = 1;
        tick();
        repeat (2) tick();
        @(negedge clk);
        check("R5 low held after transfer", {31'd0, sena_to_kernel}, 32'd0);
        wr(1'b1, 32'h000A_0A00);
        sena_pin_in = 0; xfer_start = 1;
        @(negedge clk);
        check("R5 high wins", {31'd0, sena_to_kernel}, 32'd1);
        tick();
        kernel_idle = 1;
        tick(); tick();

        // R7: masked pin ignored, unmasked mismatch sets flag
        xfer_active = 1; cs_expect = 8'h0F; cs_pin_func = 8'hFE; cs_pin_in = 8'h0E;
        tick();
        @(negedge clk);
        check("R7 masked pin ignored", {31'd0, bus_rdata[24]}, 32'd0);
        cs_pin_in = 8'h2F;
        tick();
        @(negedge clk);
        check("R7 mismatch flagged", {31'd0, bus_rdata[24]}, 32'd1);
        cs_pin_in = cs_expect;

        // R8: write 0 keeps, write 1 clears, set beats clear
        wr(1'b1, 32'h000A_0A00);
        @(negedge clk);
        check("R8 write zero keeps", {31'd0, bus_rdata[24]}, 32'd1);
        wr(1'b1, 32'h010A_0A00);
        @(negedge clk);
        check("R8 write one clears", {31'd0, bus_rdata[24]}, 32'd0);
        cs_pin_in = 8'h8F;
        wr(1'b1, 32'h010A_0A00);
        @(negedge clk);
        check("R8 set wins over clear", {31'd0, bus_rdata[24]}, 32'd1);
        wr(1'b0, 32'h0100_0000);
        @(negedge clk);
        check("R9 unprivileged clear ignored", {31'd0, bus_rdata[24]}, 32'd1);

        // randomized phase, compared every cycle by the model
        for (int n = 0; n < 4000; n++) begin
            bit [31:0] d;
            d = $urandom;
            if ($urandom_range(1, 0) == 1) d[11:8] = 4'hA;
            bus_wr_en = ($urandom_range(3, 0) == 0);
            bus_priv  = ($urandom_range(3, 0) != 0);
            bus_wdata = d;
            rx_pin_in = 1'($urandom); par_in = 1'($urandom);
            sena_pin_in = 1'($urandom);
            sena_pin_func = ($urandom_range(4, 0) != 0);
            xfer_start = ($urandom_range(7, 0) == 0);
            kernel_idle = ($urandom_range(5, 0) == 0);
            xfer_active = 1'($urandom);
            cs_expect = 8'($urandom);
            cs_pin_func = 8'($urandom);
            cs_pin_in = cs_expect ^ (8'($urandom) & 8'($urandom) & 8'($urandom) & 8'($urandom));
            @(posedge clk); #1;
        end

        @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule